// File: doc/BRIEF.md
# Keyboard Character Latch with Ready Flag

This block holds the last character delivered by a keyboard source and presents it to an 8-bit CPU bus as a memory-mapped input register. The keyboard side pushes a 7-bit code together with a one-cycle valid pulse. The block stores the code in the low seven bits of its register and sets the top bit as a "key waiting" flag.

Software polls the data location and sees the flag together with the character. It then touches a second location, the strobe, to acknowledge the key. Any read or write there drops the flag. A read of the strobe location also returns the character with the flag already cleared.

Both locations sit in a 4 KiB I/O window selected by the top address nibble. Inside that window only the low address byte is decoded, so every 256-byte page of the window mirrors the same two registers. Every other location reads as zero, and writes to the data location are ignored.

Top module: `kbd_strobe_latch`

## Requirements
- R1: While rst_ni is low the latch is 0x00, so a read of the data location returns 0x00.
- R2: A cycle with key_vld_i high loads key_code_i into bits 6:0 and sets bit 7. The new byte is readable from the next cycle on.
- R3: A read (rd_i high) at low byte 0x00 of the window returns the full latched byte in the same cycle. The read does not change the latch, so the flag stays set.
- R4: A read or a write at low byte 0x10 of the window clears bit 7 and keeps bits 6:0. A read there returns the byte with bit 7 already 0 in that same cycle.
- R5: The window is 0xC000 to 0xCFFF (addr_i[15:12] = 0xC). Inside it, addr_i[11:8] is not decoded. At addresses outside the window, reads return 0x00 and strobe-offset accesses do not clear the flag.
- R6: Inside the window, reads at any low byte other than 0x00 and 0x10 return 0x00. rd_data_o is 0x00 whenever rd_i is low.
- R7: A write at the data location (low byte 0x00) leaves the latch unchanged.
- R8: If key_vld_i and a strobe access occur in the same cycle, the new key is loaded and bit 7 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_vld_i | input | 1 | One-cycle pulse: a new character is present |
| key_code_i | input | 7 | Character code from the keyboard source |
| addr_i | input | 16 | CPU address |
| rd_i | input | 1 | CPU read strobe |
| wr_i | input | 1 | CPU write strobe |
| rd_data_o | output | 8 | Read data; combinational, zero when not selected |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 7-bit code, window tag 0xC, data offset 0x00 and strobe offset 0x10.

These values place the mirror pages 0xC100 to 0xCF00 and the neighbouring pages 0xB000 and 0xD000 inside a short vector walk. A single table can therefore cover all of the following:
- the decode boundaries on both sides of the window;
- strobe acknowledgement through both a read and a write;
- the same-cycle collision of a new key with a strobe;
- a mid-run reset.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef struct packed {
    logic data_hit;
    logic strb_hit;
  } kbd_sel_t;
endpackage

// File: rtl/kbd_addr_dec.sv
module kbd_addr_dec
  import kbd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned TAG_W     = 4,
  parameter logic [TAG_W-1:0] WIN_TAG = 4'hC,
  parameter logic [7:0] DATA_OFS   = 8'h00,
  parameter logic [7:0] STRB_OFS   = 8'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output kbd_sel_t          sel_o
);
  localparam int unsigned TAG_LSB = ADDR_W - TAG_W;

  logic in_win;
  assign in_win         = (addr_i[ADDR_W-1:TAG_LSB] == WIN_TAG);
  // middle address bits are left undecoded: pages mirror
  assign sel_o.data_hit = in_win && (addr_i[7:0] == DATA_OFS);
  assign sel_o.strb_hit = in_win && (addr_i[7:0] == STRB_OFS);
endmodule

// File: rtl/kbd_latch.sv
module kbd_latch #(
  parameter int unsigned CODE_W = 7,
  localparam int unsigned DATA_W = CODE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_vld_i,
  input  logic [CODE_W-1:0] key_code_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] q_o
);
  logic              ready_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      code_q  <= '0;
    end else if (key_vld_i) begin
      // a new key beats a simultaneous acknowledge
      ready_q <= 1'b1;
      code_q  <= key_code_i;
    end else if (ack_i) begin
      ready_q <= 1'b0;
    end
  end

  assign q_o = {ready_q, code_q};
endmodule

// File: rtl/kbd_rd_mux.sv
module kbd_rd_mux
  import kbd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rd_i,
  input  kbd_sel_t          sel_i,
  input  logic [DATA_W-1:0] q_i,
  output logic [DATA_W-1:0] rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    if (rd_i) begin
      if (sel_i.data_hit)      rd_data_o = q_i;
      else if (sel_i.strb_hit) rd_data_o = {1'b0, q_i[DATA_W-2:0]};
    end
  end
endmodule

// File: rtl/kbd_strobe_latch.sv
module kbd_strobe_latch
  import kbd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CODE_W    = 7,
  parameter int unsigned TAG_W     = 4,
  parameter logic [TAG_W-1:0] WIN_TAG = 4'hC,
  parameter logic [7:0] DATA_OFS   = 8'h00,
  parameter logic [7:0] STRB_OFS   = 8'h10,
  localparam int unsigned DATA_W   = CODE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_vld_i,
  input  logic [CODE_W-1:0] key_code_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  kbd_sel_t          sel;
  logic [DATA_W-1:0] q;
  logic              ack;

  kbd_addr_dec #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .WIN_TAG(WIN_TAG),
    .DATA_OFS(DATA_OFS), .STRB_OFS(STRB_OFS)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  assign ack = (rd_i || wr_i) && sel.strb_hit;

  kbd_latch #(.CODE_W(CODE_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_vld_i (key_vld_i),
    .key_code_i(key_code_i),
    .ack_i     (ack),
    .q_o       (q)
  );

  kbd_rd_mux #(.DATA_W(DATA_W)) u_mux (
    .rd_i     (rd_i),
    .sel_i    (sel),
    .q_i      (q),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/kbd_strobe_latch_chk.sv
module kbd_strobe_latch_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CODE_W    = 7,
  parameter int unsigned TAG_W     = 4,
  parameter logic [TAG_W-1:0] WIN_TAG = 4'hC,
  parameter logic [7:0] DATA_OFS   = 8'h00,
  parameter logic [7:0] STRB_OFS   = 8'h10,
  localparam int unsigned DATA_W   = CODE_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              key_vld_i,
  input logic [CODE_W-1:0] key_code_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [DATA_W-1:0] q
);
  logic win, at_data, at_strb, touch_strb;
  assign win        = addr_i[ADDR_W-1:ADDR_W-TAG_W] == WIN_TAG;
  assign at_data    = win && addr_i[7:0] == DATA_OFS;
  assign at_strb    = win && addr_i[7:0] == STRB_OFS;
  assign touch_strb = (rd_i || wr_i) && at_strb;

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> q == '0); // R1
  AST_KEY_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_vld_i |=> q == {1'b1, $past(key_code_i)}); // R2
  AST_READ_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && at_data && !key_vld_i |=> $stable(q)); // R3
  AST_STROBE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_strb && !key_vld_i |=> !q[DATA_W-1]); // R4
  AST_OUTSIDE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win |-> rd_data_o == '0); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rd_data_o == '0); // R6
  AST_WRITE_NOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !rd_i && at_data && !key_vld_i |=> $stable(q)); // R7
  AST_KEY_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_vld_i && touch_strb |=> q[DATA_W-1]); // R8
endmodule

bind kbd_strobe_latch kbd_strobe_latch_chk #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .TAG_W(TAG_W), .WIN_TAG(WIN_TAG),
  .DATA_OFS(DATA_OFS), .STRB_OFS(STRB_OFS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .key_vld_i (key_vld_i),
  .key_code_i(key_code_i),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .rd_data_o (rd_data_o),
  .q         (q)
);

// File: tb/tb_kbd_strobe_latch.sv
module tb_kbd_strobe_latch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        key_vld_i = 1'b0;
  logic [6:0]  key_code_i = '0;
  logic [15:0] addr_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  rd_data_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  kbd_strobe_latch dut (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        kv;
    logic [6:0]  code;
    logic [15:0] addr;
    logic        rd;
    logic        wr;
    logic [7:0]  exp;
  } vec_t;

  // exp is rd_data_o in the vector's own cycle, before the edge updates the latch
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b0, 7'h00, 16'hC000, 1'b1, 1'b0, 8'h00}, // R1 post-reset read
    '{4'd2, 1'b1, 7'h41, 16'hC000, 1'b1, 1'b0, 8'h00}, // R2 key arrives
    '{4'd2, 1'b0, 7'h00, 16'hC000, 1'b1, 1'b0, 8'hC1}, // R2 visible
    '{4'd3, 1'b0, 7'h00, 16'hC000, 1'b1, 1'b0, 8'hC1}, // R3 read keeps flag
    '{4'd4, 1'b0, 7'h00, 16'hC010, 1'b1, 1'b0, 8'h41}, // R4 strobe read
    '{4'd4, 1'b0, 7'h00, 16'hC000, 1'b1, 1'b0, 8'h41}, // R4 flag gone
    '{4'd7, 1'b0, 7'h00, 16'hC000, 1'b0, 1'b1, 8'h00}, // R7 write data loc
    '{4'd7, 1'b0, 7'h00, 16'hC000, 1'b1, 1'b0, 8'h41}, // R7 unchanged
    '{4'd6, 1'b1, 7'h5A, 16'hC005, 1'b1, 1'b0, 8'h00}, // R6 undefined offset
    '{4'd5, 1'b0, 7'h00, 16'hCF00, 1'b1, 1'b0, 8'hDA}, // R5 mirror page
    '{4'd5, 1'b0, 7'h00, 16'hD000, 1'b1, 1'b0, 8'h00}, // R5 above window
    '{4'd5, 1'b0, 7'h00, 16'hB010, 1'b1, 1'b0, 8'h00}, // R5 below, no clear
    '{4'd5, 1'b0, 7'h00, 16'hC000, 1'b1, 1'b0, 8'hDA}, // R5 flag kept
    '{4'd4, 1'b0, 7'h00, 16'hC110, 1'b0, 1'b1, 8'h00}, // R4 strobe by write
    '{4'd4, 1'b0, 7'h00, 16'hC000, 1'b1, 1'b0, 8'h5A}, // R4 cleared
    '{4'd8, 1'b1, 7'h33, 16'hC010, 1'b1, 1'b0, 8'h5A}, // R8 collision
    '{4'd8, 1'b0, 7'h00, 16'hC000, 1'b1, 1'b0, 8'hB3}, // R8 key won
    '{4'd6, 1'b0, 7'h00, 16'hC0FF, 1'b1, 1'b0, 8'h00}  // R6 last offset
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (2000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    addr_i = 16'hC000; rd_i = 1'b1;
    repeat (2) @(negedge clk_i);
    #1 check("R1 in reset", rd_data_o, 8'h00);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      key_vld_i  = VECS[i].kv;
      key_code_i = VECS[i].code;
      addr_i     = VECS[i].addr;
      rd_i       = VECS[i].rd;
      wr_i       = VECS[i].wr;
      #1 check($sformatf("R%0d vec%0d", VECS[i].req, i), rd_data_o, VECS[i].exp);
    end
    // directed: reset after a key is held
    @(negedge clk_i);
    key_vld_i = 1'b0; rd_i = 1'b1; wr_i = 1'b0; addr_i = 16'hC000;
    #1 check("R1 pre-reset", rd_data_o, 8'hB3);
    rst_ni = 1'b0;
    #1 check("R1 async reset", rd_data_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // directed: key then write to strobe of last mirror page
    key_vld_i = 1'b1; key_code_i = 7'h7F; rd_i = 1'b0;
    @(negedge clk_i);
    key_vld_i = 1'b0; rd_i = 1'b1;
    #1 check("R2 max code", rd_data_o, 8'hFF);
    addr_i = 16'hCF10; rd_i = 1'b0; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b1; addr_i = 16'hC000;
    #1 check("R5 R4 mirror strobe", rd_data_o, 8'h7F);
    rd_i = 1'b0;
    #1 check("R6 idle zero", rd_data_o, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule